// File: doc/BRIEF.md
# Programmable Interrupt Request Aggregator

This block collects a bank of external interrupt request lines and folds them into one interrupt to the processor. Software sets, for each line, whether it is level- or edge-sensitive and which polarity counts as active. Every input passes through a two-flop synchronizer. A level line reports its qualified input level. An edge line holds a sticky pending bit that only a software clear removes. A per-line enable mask decides which pending lines drive the combined output. A summary register shows the pending lines, restricted to a mask of the lines that the board variant implements.

A set of lines is reserved. They have no capture logic and can never report a request. Software clears requests through a clear register. A bit written as 1 stays in force until software writes the register back to zero. A separate reset register starts a fixed-length board-reset pulse, but only when it is written with one specific key value.

The host reaches the registers through a simple bus: one write strobe, a word address, write data, and combinational read data.

Top module: `intr_gather`

## Requirements
- R1: After reset the enable mask, the edge-select register and the clear register read 0, the polarity register reads 0x8000_0000 (only line 31 active-high), `irq_out` is 0 and `board_rst` is 0.
- R2: The enable mask (address 0), edge-select (address 1), polarity (address 2) and clear (address 3) registers read back the last value written. Address 5 reads as 0.
- R3: In level mode (edge-select bit 0), summary bit i (address 4) equals the qualified input. A polarity bit of 1 makes the line active-high and 0 makes it active-low. A change at the pin reaches the summary within three clock edges.
- R4: In edge mode (edge-select bit 1), an active transition sets a pending bit: rising when the polarity bit is 1, falling when it is 0. The bit stays set after the input returns to its idle level.
- R5: A clear-register bit of 1 removes an edge line's pending bit. While that clear bit stays 1, edges on the line are dropped. After the register is written back to 0, new edges are captured again.
- R6: A level line ignores a clear bit that is held at 1. It keeps reporting its qualified level in the cycles after the write.
- R7: Lines in the reserved set (bits 20 to 30 by default) never report a request, whatever their input, polarity or mode.
- R8: The summary register shows only the lines in the implemented-bits parameter. Other bits read 0.
- R9: `irq_out` is the OR over all lines of pending AND enable mask AND implemented bits. It is registered one cycle behind the summary, so an enable mask of 0 keeps it low.
- R10: Writing 0x0000_DEAD to address 5 drives `board_rst` high for exactly 16 cycles, starting with the clock edge of the write. Any other value written there produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 32 | Raw external request lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Combined interrupt to the processor |
| board_rst | output | 1 | Board reset pulse |

## Verification
Every cycle, the assertions check four things. A level line's pending bit tracks its synchronized, polarity-qualified input. An edge line's pending bit stays set until a clear acts, and no edge line is pending while its clear bit is held. The combined output matches the masked pending set one cycle later. The board-reset pulse only starts after a key write and never runs longer than its length. The bench scenarios cover the rest: register readback, the input-to-summary latency, the implemented-bits restriction and reserved-line silence at the summary port, recapture after the clear is released, and the exact pulse length for the key compared with a wrong value.

// File: rtl/intr_gather_pkg.sv
package intr_gather_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  typedef enum logic [REG_ADDR_W-1:0] {
    A_ENABLE = 3'd0,
    A_EDGE   = 3'd1,
    A_POL    = 3'd2,
    A_CLEAR  = 3'd3,
    A_SUMM   = 3'd4,
    A_BRST   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= IDLE;
      stage2_q <= IDLE;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/intr_line_bank.sv
module intr_line_bank #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] clr_hold,
  input  logic [N-1:0] clr_strobe,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (RSVD[i]) begin : g_rsvd
      assign pend[i] = 1'b0;
    end else begin : g_live
      logic act, act_q, pend_q, pend_d;

      assign act = pol[i] ? lvl[i] : ~lvl[i];

      always_comb begin
        if (edge_sel[i]) begin
          pend_d = clr_hold[i] ? 1'b0 : (pend_q | (act & ~act_q));
        end else begin
          pend_d = act & ~clr_strobe[i];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          act_q  <= act;
          pend_q <= pend_d;
        end
      end

      assign pend[i] = pend_q;
    end
  end
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_gather_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] POL_INIT = '0,
  parameter logic [N-1:0] KEY = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [N-1:0]          wdata,
  input  logic [N-1:0]          summary,
  output logic [N-1:0]          rdata,
  output logic [N-1:0]          enable_q,
  output logic [N-1:0]          edge_q,
  output logic [N-1:0]          pol_q,
  output logic [N-1:0]          clr_hold,
  output logic [N-1:0]          clr_strobe,
  output logic                  key_hit
);
  logic [N-1:0] clr_q;
  logic         wr_en, wr_edge, wr_pol, wr_clr;

  assign wr_en   = we && (addr == A_ENABLE);
  assign wr_edge = we && (addr == A_EDGE);
  assign wr_pol  = we && (addr == A_POL);
  assign wr_clr  = we && (addr == A_CLEAR);
  assign key_hit = we && (addr == A_BRST) && (wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      edge_q   <= '0;
      pol_q    <= POL_INIT;
      clr_q    <= '0;
    end else begin
      if (wr_en)   enable_q <= wdata;
      if (wr_edge) edge_q   <= wdata;
      if (wr_pol)  pol_q    <= wdata;
      if (wr_clr)  clr_q    <= wdata;
    end
  end

  assign clr_strobe = wr_clr ? wdata : '0;
  assign clr_hold   = clr_q | clr_strobe;

  always_comb begin
    unique case (addr)
      A_ENABLE: rdata = enable_q;
      A_EDGE:   rdata = edge_q;
      A_POL:    rdata = pol_q;
      A_CLEAR:  rdata = clr_q;
      A_SUMM:   rdata = summary;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_rst_pulse.sv
module intr_rst_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (fire)             cnt_d = CW'(LEN);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/intr_gather.sv
module intr_gather
  import intr_gather_pkg::*;
#(
  parameter int unsigned  NUM_LINES  = 32,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 32'h800F_FFFF,
  parameter logic [NUM_LINES-1:0] RSVD_MASK = 32'h7FF0_0000,
  parameter logic [NUM_LINES-1:0] POL_INIT  = 32'h8000_0000,
  parameter logic [NUM_LINES-1:0] RST_KEY   = 32'h0000_DEAD,
  parameter int unsigned  RST_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_lines,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NUM_LINES-1:0]  bus_wdata,
  output logic [NUM_LINES-1:0]  bus_rdata,
  output logic                  irq_out,
  output logic                  board_rst
);
  logic                 rst_meta_q, srst_n;
  logic [NUM_LINES-1:0] lvl_s, pend, summary;
  logic [NUM_LINES-1:0] enable_q, edge_q, pol_q, clr_hold, clr_strobe;
  logic                 key_hit, irq_d, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  intr_sync #(.W(NUM_LINES), .IDLE(~POL_INIT)) u_sync (
    .clk(clk), .rst_n(srst_n), .d_in(irq_lines), .d_out(lvl_s)
  );

  intr_regs #(.N(NUM_LINES), .POL_INIT(POL_INIT), .KEY(RST_KEY)) u_regs (
    .clk(clk), .rst_n(srst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .summary(summary), .rdata(bus_rdata),
    .enable_q(enable_q), .edge_q(edge_q), .pol_q(pol_q),
    .clr_hold(clr_hold), .clr_strobe(clr_strobe), .key_hit(key_hit)
  );

  intr_line_bank #(.N(NUM_LINES), .RSVD(RSVD_MASK)) u_bank (
    .clk(clk), .rst_n(srst_n), .lvl(lvl_s), .pol(pol_q),
    .edge_sel(edge_q), .clr_hold(clr_hold), .clr_strobe(clr_strobe),
    .pend(pend)
  );

  intr_rst_pulse #(.LEN(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(srst_n), .fire(key_hit), .pulse(board_rst)
  );

  assign summary = pend & IMPL_MASK;
  assign irq_d   = |(summary & enable_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/intr_gather_chk.sv
module intr_gather_chk #(
  parameter int unsigned  NUM_LINES  = 32,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = '0,
  parameter logic [NUM_LINES-1:0] RSVD_MASK = '0,
  parameter int unsigned  RST_CYCLES = 16
) (
  input logic                 clk,
  input logic                 srst_n,
  input logic [NUM_LINES-1:0] lvl_s,
  input logic [NUM_LINES-1:0] pol_q,
  input logic [NUM_LINES-1:0] edge_q,
  input logic [NUM_LINES-1:0] enable_q,
  input logic [NUM_LINES-1:0] clr_hold,
  input logic [NUM_LINES-1:0] clr_strobe,
  input logic [NUM_LINES-1:0] pend,
  input logic                 key_hit,
  input logic                 irq_out,
  input logic                 board_rst
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 2);
  logic [NUM_LINES-1:0] act;
  logic [CW-1:0]        hi_cnt;

  assign act = ~(lvl_s ^ pol_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        hi_cnt <= '0;
    else if (!board_rst) hi_cnt <= '0;
    else if (hi_cnt <= CW'(RST_CYCLES)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_level_track_R3: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (((pend ^ $past(act)) & $past(~edge_q & ~clr_strobe & ~RSVD_MASK)) == '0));

  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((($past(pend) & $past(edge_q) & ~$past(clr_hold)) & ~pend) == '0));

  assert_clear_holds_R5: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((pend & $past(edge_q & clr_hold)) == '0));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (irq_out == $past(|(pend & enable_q & IMPL_MASK))));

  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(board_rst) |-> $past(key_hit));

  assert_pulse_bound_R10: assert property (@(posedge clk) disable iff (!srst_n)
    hi_cnt <= CW'(RST_CYCLES));
endmodule

bind intr_gather intr_gather_chk #(
  .NUM_LINES(NUM_LINES), .IMPL_MASK(IMPL_MASK),
  .RSVD_MASK(RSVD_MASK), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .srst_n(srst_n), .lvl_s(lvl_s), .pol_q(pol_q),
  .edge_q(edge_q), .enable_q(enable_q), .clr_hold(clr_hold),
  .clr_strobe(clr_strobe), .pend(pend), .key_hit(key_hit),
  .irq_out(irq_out), .board_rst(board_rst)
);

// File: tb/intr_gather_bench.sv
module intr_gather_bench;
  localparam logic [31:0] IMPL = 32'hFFFF_F0FF;
  localparam logic [31:0] RSVD = 32'h7FF0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_lines;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic        board_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  intr_gather #(.IMPL_MASK(IMPL)) u_intr_gather (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .board_rst(board_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_summ(input logic [31:0] pol, input logic [31:0] lines);
    return ~(lines ^ pol) & ~RSVD & IMPL;
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_lines = 32'h7FFF_FFFF;
    settle(4);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    rd(3'd0, v); chk("R1 enable", v, 32'h0);
    rd(3'd1, v); chk("R1 edge", v, 32'h0);
    rd(3'd2, v); chk("R1 polarity", v, 32'h8000_0000);
    rd(3'd3, v); chk("R1 clear", v, 32'h0);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 board_rst", {31'b0, board_rst}, 32'h0);

    // R2 readback
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = $urandom;
      wr(3'(k), w);
      rd(3'(k), v); chk("R2 readback", v, w);
    end
    rd(3'd5, v); chk("R2 addr5 reads zero", v, 32'h0);
    wr(3'd1, 32'h0); wr(3'd3, 32'h0);

    // R3/R7/R8/R9 random level patterns
    for (int k = 0; k < 24; k++) begin
      logic [31:0] p, m, l, e;
      p = $urandom; m = (k % 6 == 0) ? 32'h0 : $urandom; l = $urandom;
      if (k == 1) begin p = 32'hFFFF_FFFF; l = 32'hFFFF_FFFF; m = 32'hFFFF_FFFF; end
      wr(3'd2, p); wr(3'd0, m);
      @(negedge clk); irq_lines = l;
      settle(5);
      e = exp_summ(p, l);
      rd(3'd4, v); chk("R3 level summary", v, e);
      chk("R7 reserved silent", v & RSVD, 32'h0);
      chk("R8 impl restricted", v & ~IMPL, 32'h0);
      chk("R9 irq_out", {31'b0, irq_out}, {31'b0, |(e & m)});
    end

    // R6 level ignores held clear: line 0 active-low, driven low
    wr(3'd2, 32'h0); wr(3'd0, 32'h1);
    @(negedge clk); irq_lines = 32'hFFFF_FFFE;
    wr(3'd3, 32'hFFFF_FFFF);
    settle(3);
    rd(3'd4, v); chk("R6 level with clear held", v & 32'h1, 32'h1);
    wr(3'd3, 32'h0);

    // R4 edge capture: line 3 active-high, line 5 active-low
    @(negedge clk); irq_lines = 32'hFFFF_FFF7;
    wr(3'd2, 32'h8000_0008); wr(3'd1, 32'h28); wr(3'd0, 32'h28);
    settle(4);
    wr(3'd3, 32'h28); wr(3'd3, 32'h0);
    settle(4);
    rd(3'd4, v); chk("R4 idle no pending", v & 32'h28, 32'h0);
    @(negedge clk); irq_lines[3] = 1'b1; settle(2); irq_lines[3] = 1'b0;
    settle(5);
    rd(3'd4, v); chk("R4 rising sticky", v & 32'h28, 32'h08);
    chk("R9 irq on edge", {31'b0, irq_out}, 32'h1);
    @(negedge clk); irq_lines[5] = 1'b0; settle(2); irq_lines[5] = 1'b1;
    settle(5);
    rd(3'd4, v); chk("R4 falling sticky", v & 32'h28, 32'h28);

    // R5 clear hold and release
    wr(3'd3, 32'h08);
    settle(2);
    rd(3'd4, v); chk("R5 cleared", v & 32'h28, 32'h20);
    @(negedge clk); irq_lines[3] = 1'b1; settle(2); irq_lines[3] = 1'b0;
    settle(5);
    rd(3'd4, v); chk("R5 edge dropped while held", v & 32'h28, 32'h20);
    wr(3'd3, 32'h0);
    settle(3);
    rd(3'd4, v); chk("R5 no capture on release", v & 32'h28, 32'h20);
    @(negedge clk); irq_lines[3] = 1'b1; settle(2); irq_lines[3] = 1'b0;
    settle(5);
    rd(3'd4, v); chk("R5 recapture", v & 32'h28, 32'h28);
    wr(3'd0, 32'h0);
    settle(2);
    chk("R9 masked off", {31'b0, irq_out}, 32'h0);
    wr(3'd3, 32'h28); wr(3'd3, 32'h0);

    // R10 reset key
    begin
      int hi;
      hi = 0;
      wr(3'd5, 32'h0000_DEAE);
      repeat (30) begin @(negedge clk); if (board_rst) hi++; end
      chk("R10 wrong key", 32'(hi), 32'd0);
      hi = 0;
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0000_DEAD;
      @(negedge clk);
      bus_we = 1'b0;
      chk("R10 pulse starts", {31'b0, board_rst}, 32'h1);
      if (board_rst) hi++;
      repeat (30) begin @(negedge clk); if (board_rst) hi++; end
      chk("R10 pulse length", 32'(hi), 32'd16);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule